// File: doc/BRIEF.md
# Multi-Headstage Sampling Sequencer

This block runs the sampling loop for several headstage amplifier chips that share one serial clock, one chip-select and one command line. Each headstage answers on its own data-return line. All of them are captured in parallel, bit by bit, during the same frames. A pulse on `sample_tick` starts one loop, so the tick rate is the system sample rate, typically 10 to 30 kHz. A loop is a fixed run of 16-bit SPI mode-0 frames. The neural frames come first and request one channel each, in ascending channel order. Three auxiliary frames follow, and they carry host-supplied command words.

When a loop finishes, the block publishes one sample record on a valid/ready word stream. The record holds a timestamp, then every headstage's channel words, then every headstage's auxiliary replies, then the external input values that were latched during that loop. All of these share the one timestamp. The timestamp is a loop counter. The record is copied into a dedicated output buffer, so a slow consumer never delays serial timing.

Top module: `hs_sample_sequencer`

## Requirements
- R1: During and after reset, chip-select is high, the serial clock is low, no record is offered (`rec_valid` low) and `overrun_cnt` is zero.
- R2: A `sample_tick` seen while idle starts one loop of exactly N_CH+N_AUX (default 35) frames. Each frame has exactly 16 rising serial-clock edges while chip-select is low.
- R3: The serial clock idles low and each of its half-periods lasts SCLK_DIV system clocks. The command line changes only while the serial clock is low. Command and reply bits travel MSB first, and each reply bit is taken at a rising serial-clock edge.
- R4: Between two frames of a loop, chip-select stays high for exactly CS_GAP system clocks. CS_GAP must be at least 2.
- R5: Neural frame f (0 to N_CH-1) sends the command word with bits 15:14 = 0, bits 13:8 = f and bits 7:0 = 0.
- R6: Auxiliary frame N_CH+j sends slot j of `aux_cmd` (bits 16j+15:16j), latched at the clock edge that starts the loop. Later changes to `aux_cmd` do not affect that loop.
- R7: The 16-bit reply from headstage h in frame f is stored in the record. Every headstage is captured during the same frames.
- R8: External inputs are latched once per loop, at the clock edge where chip-select falls for frame N_CH. Value e is `ext_in` bits e*EXT_W+EXT_W-1:e*EXT_W. Values driven before or after that edge do not appear.
- R9: A record is 1+N_HS*(N_CH+N_AUX)+N_EXT words, zero-extended to DW bits. The order is: timestamp; then channel replies, headstage-major (headstage 0 channels 0..N_CH-1, then headstage 1, and so on); then auxiliary replies, headstage-major; then external values in index order. `rec_last` is high only on the final word.
- R10: The timestamp of the first loop after reset is 0 and rises by one for every loop started.
- R11: A `sample_tick` arriving while a loop runs starts nothing. It adds one to `overrun_cnt`, which saturates at all ones.
- R12: While `rec_valid` is high and `rec_ready` is low, `rec_data` and `rec_last` hold their values. Back-pressure never alters serial timing, and a loop completes all its frames while a record waits.
- R13: If a loop completes while the previous record has not been fully read, the new record is discarded. Its timestamp value is still consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse that starts a loop |
| aux_cmd | input | N_AUX*16 | Command words for the auxiliary frames, slot j at bits 16j+15:16j |
| ext_in | input | N_EXT*EXT_W | External digital/analog input values |
| spi_sclk | output | 1 | Shared serial clock |
| spi_cs_n | output | 1 | Shared chip-select, active low |
| spi_mosi | output | 1 | Shared command line |
| spi_miso | input | N_HS | One reply line per headstage |
| rec_valid | output | 1 | Record word available |
| rec_ready | input | 1 | Consumer accepts the word |
| rec_data | output | DW | Record word |
| rec_last | output | 1 | Final word of the record |
| overrun_cnt | output | OVR_W | Saturating count of ignored ticks |

## Verification
The bench builds the block with three headstages, so headstage-major ordering is checked past the two-headstage default. It uses SCLK_DIV=1, which keeps every 35-frame loop near a thousand cycles, so many loops fit in one run. CS_GAP=3 separates an exact-gap check from the minimum the assertion enforces. A 2-bit overrun counter reaches saturation within a few stray ticks. A model headstage on each return line answers with words that encode headstage, loop and frame, so any misplacement in the record shows up as a wrong value.

// File: rtl/hs_sample_sequencer.sv
module hs_sample_sequencer #(
  parameter int N_HS     = 2,
  parameter int N_CH     = 32,
  parameter int N_AUX    = 3,
  parameter int N_EXT    = 8,
  parameter int EXT_W    = 16,
  parameter int SCLK_DIV = 2,
  parameter int CS_GAP   = 2,
  parameter int TS_W     = 32,
  parameter int DW       = 32,
  parameter int OVR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_tick,
  input  logic [N_AUX*16-1:0]    aux_cmd,
  input  logic [N_EXT*EXT_W-1:0] ext_in,
  output logic                   spi_sclk,
  output logic                   spi_cs_n,
  output logic                   spi_mosi,
  input  logic [N_HS-1:0]        spi_miso,
  output logic                   rec_valid,
  input  logic                   rec_ready,
  output logic [DW-1:0]          rec_data,
  output logic                   rec_last,
  output logic [OVR_W-1:0]       overrun_cnt
);
  localparam int FW      = 16;
  localparam int N_FR    = N_CH + N_AUX;
  localparam int N_SLOT  = N_HS * N_FR;
  localparam int REC_LEN = 1 + N_SLOT + N_EXT;
  localparam int FR_W    = $clog2(N_FR + 1);
  localparam int DIV_W   = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int GAP_W   = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam int IDX_W   = $clog2(REC_LEN);
  localparam int SL_W    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam int EI_W    = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;

  state_t            st;
  logic [DIV_W-1:0]  div_cnt;
  logic [3:0]        bit_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [FR_W-1:0]   frame, load_fr, aux_i;
  logic              sclk_q, cs_n_q;
  logic [FW-1:0]     tx_sh, load_cmd;
  logic [FW-1:0]     rx_sh [N_HS];
  logic [SL_W-1:0]   wr_idx [N_HS];
  logic [N_AUX*FW-1:0] aux_q;
  logic [EXT_W-1:0]  ext_q [N_EXT];
  logic [FW-1:0]     cap [N_SLOT];
  logic [FW-1:0]     ob [N_SLOT];
  logic [EXT_W-1:0]  ob_ext [N_EXT];
  logic [TS_W-1:0]   ts_cnt, ts_q, ob_ts;
  logic              ob_full;
  logic [IDX_W-1:0]  rd_idx;
  logic [OVR_W-1:0]  ovr;
  int                rd_k;

  logic half_done, rise, fall, fend, gap_done, last_fr, loop_done;
  logic start, nxt_start, publish, rd_fire;

  assign half_done = (st == S_XFER) && (div_cnt == DIV_W'(SCLK_DIV - 1));
  assign rise      = half_done && !sclk_q;
  assign fall      = half_done && sclk_q;
  assign fend      = fall && (bit_cnt == 4'(FW - 1));
  assign gap_done  = (st == S_GAP) && (gap_cnt == GAP_W'(CS_GAP - 1));
  assign last_fr   = (frame == FR_W'(N_FR - 1));
  assign loop_done = gap_done && last_fr;
  assign start     = (st == S_IDLE) && sample_tick;
  assign nxt_start = start || (gap_done && !last_fr);
  assign publish   = loop_done && !ob_full;
  assign rd_fire   = ob_full && rec_ready;
  assign load_fr   = (st == S_IDLE) ? '0 : frame + 1'b1;
  assign aux_i     = load_fr - FR_W'(N_CH);

  always_comb begin
    if (load_fr < FR_W'(N_CH)) load_cmd = {2'b00, 6'(load_fr), 8'h00};
    else                       load_cmd = aux_q[aux_i*FW +: FW];
  end

  for (genvar g = 0; g < N_HS; g++) begin : g_widx
    assign wr_idx[g] = (frame < FR_W'(N_CH)) ? SL_W'(g*N_CH + int'(frame))
                                              : SL_W'(N_HS*N_CH + g*N_AUX + int'(frame) - N_CH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  div_cnt <= '0;  bit_cnt <= '0;  gap_cnt <= '0;
      frame <= '0;   sclk_q <= 1'b0; cs_n_q <= 1'b1;
      ts_cnt <= '0;  ts_q <= '0;     ob_full <= 1'b0; rd_idx <= '0;  ovr <= '0;
    end else begin
      if (sample_tick && st != S_IDLE && ovr != '1) ovr <= ovr + 1'b1;
      if (nxt_start) begin
        st <= S_XFER;  frame <= load_fr;  cs_n_q <= 1'b0;
        bit_cnt <= '0; div_cnt <= '0;     sclk_q <= 1'b0;
      end else if (st == S_XFER) begin
        if (half_done) begin
          div_cnt <= '0;
          sclk_q  <= !sclk_q;
          if (fend) begin
            st <= S_GAP;  cs_n_q <= 1'b1;  gap_cnt <= '0;
          end else if (fall) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else if (st == S_GAP) begin
        if (gap_done) st <= S_IDLE;
        else          gap_cnt <= gap_cnt + 1'b1;
      end
      if (start) begin
        ts_q   <= ts_cnt;
        ts_cnt <= ts_cnt + 1'b1;
      end
      if (publish) begin
        ob_full <= 1'b1;
        rd_idx  <= '0;
      end else if (rd_fire) begin
        if (rd_idx == IDX_W'(REC_LEN - 1)) ob_full <= 1'b0;
        else                               rd_idx  <= rd_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (nxt_start)  tx_sh <= load_cmd;
    else if (fall)  tx_sh <= {tx_sh[FW-2:0], 1'b0};
    if (start) aux_q <= aux_cmd;
    if (nxt_start && load_fr == FR_W'(N_CH))
      for (int e = 0; e < N_EXT; e++) ext_q[e] <= ext_in[e*EXT_W +: EXT_W];
    for (int h = 0; h < N_HS; h++) begin
      if (rise) rx_sh[h] <= {rx_sh[h][FW-2:0], spi_miso[h]};
      if (fend) cap[wr_idx[h]] <= rx_sh[h];
    end
    if (publish) begin
      ob     <= cap;
      ob_ext <= ext_q;
      ob_ts  <= ts_q;
    end
  end

  assign rd_k = int'(rd_idx) - 1;

  always_comb begin
    if (rd_idx == '0)      rec_data = DW'(ob_ts);
    else if (rd_k < N_SLOT) rec_data = DW'(ob[SL_W'(rd_k)]);
    else                   rec_data = DW'(ob_ext[EI_W'(rd_k - N_SLOT)]);
  end

  assign rec_valid   = ob_full;
  assign rec_last    = ob_full && (rd_idx == IDX_W'(REC_LEN - 1));
  assign spi_sclk    = sclk_q;
  assign spi_cs_n    = cs_n_q;
  assign spi_mosi    = !cs_n_q && tx_sh[FW-1];
  assign overrun_cnt = ovr;

  a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r3_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r4_cs_high_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  a_r12_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last)));

  a_r11_busy_tick_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !spi_cs_n) |=> (overrun_cnt != '0));

endmodule

// File: tb/hs_sample_sequencer_test.sv
`timescale 1ns/1ps
module hs_sample_sequencer_test;
  localparam int NHS = 3, NCH = 32, NAUX = 3, NEXT = 8, EXTW = 16;
  localparam int DIV = 1, GAP = 3, OVRW = 2;
  localparam int NFR = NCH + NAUX;
  localparam int REC_LEN = 1 + NHS*NFR + NEXT;

  // fields: a0 | a1 | a2 | ext base | ready mask
  localparam logic [79:0] VEC [4] = '{
    {16'h8001, 16'h8102, 16'hC0FF, 16'h1000, 16'hFFFF},
    {16'h0F0F, 16'hF0F0, 16'h5A5A, 16'h2345, 16'hAAAA},
    {16'hFFFF, 16'h0000, 16'h1234, 16'hFFF0, 16'h3333},
    {16'h7E81, 16'h4242, 16'hBEEF, 16'h0007, 16'h0F0F}
  };

  logic clk = 0, rst_n = 0, sample_tick = 0, rec_ready = 0;
  logic [NAUX*16-1:0] aux_cmd = '0;
  logic [NEXT*EXTW-1:0] ext_in = '0;
  logic spi_sclk, spi_cs_n, spi_mosi, rec_valid, rec_last;
  logic [NHS-1:0] spi_miso;
  logic [31:0] rec_data;
  logic [OVRW-1:0] overrun_cnt;

  int total = 0, bad = 0;
  int ftot = 0, loop_base = 0, loop_no = 0;
  int bcnt = 0, bad_bits = 0, hi_run = 0, min_gap = 1000000;
  logic [15:0] mosi_sh = '0;
  logic [15:0] cmd_log [64];
  logic [15:0] ssh [NHS];

  always #10 clk = ~clk;

  hs_sample_sequencer #(.N_HS(NHS), .N_CH(NCH), .N_AUX(NAUX), .N_EXT(NEXT), .EXT_W(EXTW),
    .SCLK_DIV(DIV), .CS_GAP(GAP), .TS_W(32), .DW(32), .OVR_W(OVRW)) uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .aux_cmd(aux_cmd), .ext_in(ext_in),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data), .rec_last(rec_last),
    .overrun_cnt(overrun_cnt));

  function automatic logic [15:0] resp(int h, int ln, int f);
    return {4'(h), 4'(ln), 8'(f)};
  endfunction

  for (genvar g = 0; g < NHS; g++) begin : g_miso
    assign spi_miso[g] = ssh[g][15];
  end

  always @(posedge spi_sclk) if (rst_n && !spi_cs_n) begin
    mosi_sh = {mosi_sh[14:0], spi_mosi};
    bcnt++;
  end

  always @(posedge spi_cs_n) if (rst_n) begin
    if (ftot - loop_base >= 0 && ftot - loop_base < 64) cmd_log[ftot - loop_base] = mosi_sh;
    if (bcnt != 16) bad_bits++;
    bcnt = 0;
    ftot++;
  end

  always @(negedge spi_cs_n) if (rst_n)
    for (int h = 0; h < NHS; h++) ssh[h] = resp(h, loop_no, ftot - loop_base);

  always @(negedge spi_sclk) if (rst_n && !spi_cs_n)
    for (int h = 0; h < NHS; h++) ssh[h] = ssh[h] << 1;

  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int idx, int ln, int ts, logic [15:0] eb);
    int k;
    if (idx == 0) return 32'(ts);
    k = idx - 1;
    if (k < NHS*NCH) return {16'h0, resp(k / NCH, ln, k % NCH)};
    k -= NHS*NCH;
    if (k < NHS*NAUX) return {16'h0, resp(k / NAUX, ln, NCH + k % NAUX)};
    k -= NHS*NAUX;
    return {16'h0, 16'(eb + 16'(k))};
  endfunction

  task automatic run_loop(int ln, logic [15:0] a0, a1, a2, eb);
    loop_base = ftot;
    loop_no = ln;
    aux_cmd = {a2, a1, a0};
    ext_in = {NEXT{16'hDEAD}};
    @(negedge clk) sample_tick = 1;
    @(negedge clk) sample_tick = 0;
    repeat (4) @(negedge clk);
    aux_cmd = ~{a2, a1, a0};
    wait (ftot - loop_base == NCH);
    @(negedge clk);
    for (int e = 0; e < NEXT; e++) ext_in[e*EXTW +: EXTW] = 16'(eb + 16'(e));
    @(negedge spi_cs_n);
    @(negedge clk);
    ext_in = {NEXT{16'hBEEF}};
    wait (ftot - loop_base == NFR);
    repeat (GAP + 2) @(negedge clk);
  endtask

  task automatic check_cmds(logic [15:0] a0, a1, a2);
    for (int f = 0; f < NCH; f++) chk("R5 R3 neural command", {16'h0, cmd_log[f]}, 32'(f << 8));
    chk("R6 aux slot 0", {16'h0, cmd_log[NCH]},     {16'h0, a0});
    chk("R6 aux slot 1", {16'h0, cmd_log[NCH + 1]}, {16'h0, a1});
    chk("R6 aux slot 2", {16'h0, cmd_log[NCH + 2]}, {16'h0, a2});
    chk("R2 frames per loop", 32'(ftot - loop_base), 32'(NFR));
    chk("R2 bits per frame", 32'(bad_bits), 32'd0);
  endtask

  task automatic drain(int ln, int ts, logic [15:0] eb, logic [15:0] mask);
    int idx = 0, cyc = 0;
    logic stalled = 0;
    logic [31:0] held = '0;
    wait (rec_valid);
    while (idx < REC_LEN) begin
      @(negedge clk);
      if (stalled) chk("R12 data held while stalled", rec_data, held);
      rec_ready = mask[cyc % 16];
      cyc++;
      stalled = rec_valid && !rec_ready;
      held = rec_data;
      if (rec_ready && rec_valid) begin
        if (idx == 0)                 chk("R10 timestamp", rec_data, exp_word(idx, ln, ts, eb));
        else if (idx <= NHS*NFR)      chk("R7 R3 reply word", rec_data, exp_word(idx, ln, ts, eb));
        else                          chk("R8 external value", rec_data, exp_word(idx, ln, ts, eb));
        chk("R9 last flag", {31'h0, rec_last}, {31'h0, idx == REC_LEN - 1});
        idx++;
      end
    end
    @(negedge clk);
    rec_ready = 0;
    chk("R9 record drained", {31'h0, rec_valid}, 32'd0);
  endtask

  initial begin : main
    logic [79:0] v;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", {31'h0, spi_cs_n}, 32'd1);
    chk("R1 sclk in reset", {31'h0, spi_sclk}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 rec_valid after reset", {31'h0, rec_valid}, 32'd0);
    chk("R1 overrun after reset", 32'(overrun_cnt), 32'd0);
    chk("R1 cs_n after reset", {31'h0, spi_cs_n}, 32'd1);

    for (int k = 0; k < 4; k++) begin
      v = VEC[k];
      run_loop(k, v[79:64], v[63:48], v[47:32], v[31:16]);
      check_cmds(v[79:64], v[63:48], v[47:32]);
      chk("R11 no overrun on clean ticks", 32'(overrun_cnt), 32'd0);
      drain(k, k, v[31:16], v[15:0]);
    end

    // R12/R13: record left unread while the next loop runs
    run_loop(4, 16'h1111, 16'h2222, 16'h3333, 16'h0400);
    chk("R12 record waiting", {31'h0, rec_valid}, 32'd1);
    run_loop(5, 16'h4444, 16'h5555, 16'h6666, 16'h0500);
    chk("R12 loop completes under back-pressure", 32'(ftot - loop_base), 32'(NFR));
    chk("R13 older record kept", rec_data, 32'd4);
    drain(4, 4, 16'h0400, 16'hFFFF);
    run_loop(6, 16'h7777, 16'h8888, 16'h9999, 16'h0600);
    check_cmds(16'h7777, 16'h8888, 16'h9999);
    drain(6, 6, 16'h0600, 16'h5555);

    // R11: ticks during a running loop
    loop_base = ftot;
    loop_no = 7;
    aux_cmd = {16'hCCCC, 16'hBBBB, 16'hAAAA};
    for (int e = 0; e < NEXT; e++) ext_in[e*EXTW +: EXTW] = 16'(16'h0700 + 16'(e));
    @(negedge clk) sample_tick = 1;
    @(negedge clk) sample_tick = 0;
    repeat (20) @(negedge clk);
    sample_tick = 1;
    @(negedge clk) sample_tick = 0;
    @(negedge clk);
    chk("R11 overrun counts one", 32'(overrun_cnt), 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) sample_tick = 1;
      @(negedge clk) sample_tick = 0;
    end
    @(negedge clk);
    chk("R11 overrun saturates", 32'(overrun_cnt), 32'd3);
    wait (ftot - loop_base == NFR);
    repeat (50) @(negedge clk);
    chk("R11 stray ticks start nothing", 32'(ftot - loop_base), 32'(NFR));
    chk("R11 idle after loop", {31'h0, spi_cs_n}, 32'd1);
    check_cmds(16'hAAAA, 16'hBBBB, 16'hCCCC);
    drain(7, 7, 16'h0700, 16'hFFFF);

    chk("R4 chip-select gap", 32'(min_gap), 32'(GAP));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R2 run did not finish actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule